// File: doc/BRIEF.md
# Erase-Block Write-Protection Manager

This block keeps the write-protection state of every erase block in a 1M x 16-bit boot-block flash array. The array has 39 erase blocks: 8 small parameter blocks of 4K words and 31 main blocks of 32K words. A parameter puts the parameter blocks at either the high end or the low end of the word address space. The block handles lock, unlock and lock-down requests. It decides whether each program or erase start may go ahead, and it keeps a sticky protection-error flag. Any block's two-bit lock status can be read at any time through a status address.

Each block holds two state bits: a lock bit and a lock-down bit. The lock-down bit takes effect only while the write-protect pin is low. While it does, the block is frozen and counts as locked. With the pin high the block can be locked and unlocked freely, but its lock-down bit stays set. The lock-down bit clears only on hardware reset. The program-voltage status is sampled only in the cycle an operation starts. A start made while the voltage is below lockout is refused, whatever the block state.

Top module: `fbp_prot_mgr`

## Requirements
- R1: During and after reset every block reads status 2'b01 (locked, not locked-down), and `prot_err_o` is 0.
- R2: Block decode with TOP_BOOT=1: the last 32K words (0xF8000 to 0xFFFFF) form eight 4K-word parameter blocks, and the rest is split into 32K-word main blocks from address 0. With TOP_BOOT=0 the parameter blocks fill the first 32K words and the main blocks follow. A request acts on exactly the block that holds its address.
- R3: `lk_cmd_i` encodes 2'b00 none, 2'b01 lock, 2'b10 unlock, 2'b11 lock-down. On a block that is not frozen, unlock makes the status read 2'b00 and lock makes it read 2'b01 after the clock edge that takes the request.
- R4: Lock-down makes the block's status bit 1 read 1. While write-protect `wp_i` is 0, a locked-down block reads 2'b11 and lock or unlock requests leave its state unchanged.
- R5: While `wp_i` is 1, unlocking a locked-down block makes it read 2'b10, and program/erase is then permitted. Driving `wp_i` to 0 again makes it read 2'b11 and protected.
- R6: An `op_start_i` on an unprotected block with `vpp_ok_i`=1 pulses `op_grant_o` for exactly one cycle, in the cycle after the start, with `op_deny_o` at 0.
- R7: An `op_start_i` on a protected block (status bit 0 is 1), or with `vpp_ok_i`=0, pulses `op_deny_o` in the cycle after the start and sets `prot_err_o` in the same cycle.
- R8: `vpp_ok_i` is looked at only in the start cycle. Changing it in the following cycles does not alter the verdict already given.
- R9: `prot_err_o` stays set until `err_clr_i` is taken at a clock edge or reset occurs. A new denial in the same cycle as a clear leaves the flag set.
- R10: No request clears the lock-down bit. Hardware reset returns a locked-down block to 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low; locks all blocks |
| wp_i | input | 1 | Write-protect pin level; 0 enforces lock-down |
| lk_cmd_i | input | 2 | Lock request code (none, lock, unlock, lock-down) |
| lk_addr_i | input | ADDR_W | Word address selecting the block for the lock request |
| op_start_i | input | 1 | One-cycle start of a program or erase |
| op_addr_i | input | ADDR_W | Word address of the program or erase |
| vpp_ok_i | input | 1 | Program voltage above lockout (1) or below it (0) |
| err_clr_i | input | 1 | Clears the protection-error flag |
| op_grant_o | output | 1 | Operation permitted, one-cycle pulse |
| op_deny_o | output | 1 | Operation refused, one-cycle pulse |
| prot_err_o | output | 1 | Sticky protection-error flag |
| st_addr_i | input | ADDR_W | Word address whose block status is read |
| st_lock_o | output | 2 | Status of that block: bit 0 locked, bit 1 locked-down |

## Verification
The assertions assume that `op_start_i` is a single-cycle pulse and that every input is steady at the clock edge. They also assume that at most one lock request is presented per cycle, and that reset is held across at least one edge. The bench drives every input on the falling edge, holds each request or start for exactly one cycle and returns the request code to none afterwards. It reads status and verdicts on the next falling edge, so no sampled value can fall between the sampling point and a change of the input.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   typedef enum logic [1:0] {
      CMD_NONE   = 2'b00,
      CMD_LOCK   = 2'b01,
      CMD_UNLOCK = 2'b10,
      CMD_DOWN   = 2'b11
   } lk_cmd_e;
endpackage

// File: rtl/fbp_blk_decode.sv
module fbp_blk_decode #(
   parameter int ADDR_W     = 20,
   parameter int MAIN_LOG2  = 15,
   parameter int PARAM_LOG2 = 12,
   parameter int N_PARAM    = 8,
   parameter bit TOP_BOOT   = 1'b1,
   parameter int IDX_W      = 6
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int SLOT_W = ADDR_W - MAIN_LOG2;
   localparam int SUB_W  = MAIN_LOG2 - PARAM_LOG2;
   localparam int N_SLOT = 2 ** SLOT_W;
   localparam int N_MAIN = N_SLOT - 1;

   logic [SLOT_W-1:0] slot;
   logic [SUB_W-1:0]  sub;
   logic              unused_low;

   assign slot       = addr_i[ADDR_W-1:MAIN_LOG2];
   assign sub        = addr_i[MAIN_LOG2-1:PARAM_LOG2];
   assign unused_low = ^addr_i[PARAM_LOG2-1:0];

   generate
      if (TOP_BOOT) begin : g_top
         always_comb begin
            if (slot == SLOT_W'(N_SLOT - 1))
               idx_o = IDX_W'(N_MAIN) + IDX_W'(sub);
            else
               idx_o = IDX_W'(slot);
         end
      end else begin : g_bottom
         always_comb begin
            if (slot == '0)
               idx_o = IDX_W'(sub);
            else
               idx_o = IDX_W'(slot) + IDX_W'(N_PARAM - 1);
         end
      end
   endgenerate
endmodule

// File: rtl/fbp_blk_cell.sv
module fbp_blk_cell
   import fbp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wp_i,
   input  logic       hit_i,
   input  lk_cmd_e    cmd_i,
   output logic [1:0] stat_o
);
   logic lock_q;
   logic down_q;
   logic frozen;

   assign frozen = down_q & ~wp_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b1;
         down_q <= 1'b0;
      end else if (hit_i) begin
         unique case (cmd_i)
            CMD_LOCK:   if (!frozen) lock_q <= 1'b1;
            CMD_UNLOCK: if (!frozen) lock_q <= 1'b0;
            CMD_DOWN: begin
               if (!frozen) lock_q <= 1'b1;
               down_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign stat_o = {down_q, lock_q | frozen};

   // R4: a frozen block keeps its lock bit whatever is requested
   a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> $stable(lock_q));
   // R10: no request clears lock-down
   a_r10_down_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      down_q |=> down_q);
   a_r4_down_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && cmd_i == CMD_DOWN) |=> down_q);
endmodule

// File: rtl/fbp_op_gate.sv
module fbp_op_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic vpp_ok_i,
   input  logic blk_prot_i,
   input  logic clr_i,
   output logic grant_o,
   output logic deny_o,
   output logic err_o
);
   logic refuse;

   assign refuse = start_i & (blk_prot_i | ~vpp_ok_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_o <= 1'b0;
         deny_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         grant_o <= start_i & ~refuse;
         deny_o  <= refuse;
         err_o   <= (err_o & ~clr_i) | refuse;
      end
   end

   a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_o && deny_o));
   a_r6_verdict_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o || deny_o) |-> $past(start_i));
   a_r7_deny_flags: assert property (@(posedge clk) disable iff (!rst_n)
      deny_o |-> err_o);
   a_r7_lockout_denies: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !vpp_ok_i) |=> deny_o);
   // R8: the verdict depends on the voltage in the start cycle only
   a_r8_start_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && vpp_ok_i && !blk_prot_i) |=> grant_o);
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/fbp_prot_mgr.sv
module fbp_prot_mgr
   import fbp_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int MAIN_LOG2  = 15,
   parameter int PARAM_LOG2 = 12,
   parameter int N_PARAM    = 8,
   parameter bit TOP_BOOT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_i,
   input  logic [1:0]        lk_cmd_i,
   input  logic [ADDR_W-1:0] lk_addr_i,
   input  logic              op_start_i,
   input  logic [ADDR_W-1:0] op_addr_i,
   input  logic              vpp_ok_i,
   input  logic              err_clr_i,
   output logic              op_grant_o,
   output logic              op_deny_o,
   output logic              prot_err_o,
   input  logic [ADDR_W-1:0] st_addr_i,
   output logic [1:0]        st_lock_o
);
   localparam int N_MAIN = 2 ** (ADDR_W - MAIN_LOG2) - 1;
   localparam int N_BLK  = N_MAIN + N_PARAM;
   localparam int IDX_W  = $clog2(N_BLK);

   generate
      if (N_PARAM * (2 ** PARAM_LOG2) != 2 ** MAIN_LOG2) begin : g_bad_geom
         $error("parameter blocks must exactly fill one main-block slot");
      end
      if (ADDR_W <= MAIN_LOG2 || MAIN_LOG2 <= PARAM_LOG2) begin : g_bad_width
         $error("address widths out of order");
      end
   endgenerate

   lk_cmd_e          cmd;
   logic [IDX_W-1:0] lk_idx, op_idx, st_idx;
   logic [1:0]       stat [N_BLK];
   logic             op_prot;

   assign cmd = lk_cmd_e'(lk_cmd_i);

   fbp_blk_decode #(.ADDR_W(ADDR_W), .MAIN_LOG2(MAIN_LOG2), .PARAM_LOG2(PARAM_LOG2),
                    .N_PARAM(N_PARAM), .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
      u_dec_lk (.addr_i(lk_addr_i), .idx_o(lk_idx));
   fbp_blk_decode #(.ADDR_W(ADDR_W), .MAIN_LOG2(MAIN_LOG2), .PARAM_LOG2(PARAM_LOG2),
                    .N_PARAM(N_PARAM), .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
      u_dec_op (.addr_i(op_addr_i), .idx_o(op_idx));
   fbp_blk_decode #(.ADDR_W(ADDR_W), .MAIN_LOG2(MAIN_LOG2), .PARAM_LOG2(PARAM_LOG2),
                    .N_PARAM(N_PARAM), .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
      u_dec_st (.addr_i(st_addr_i), .idx_o(st_idx));

   generate
      for (genvar b = 0; b < N_BLK; b++) begin : g_blk
         logic hit;
         assign hit = (cmd != CMD_NONE) && (lk_idx == IDX_W'(b));
         fbp_blk_cell u_cell (
            .clk(clk), .rst_n(rst_n), .wp_i(wp_i),
            .hit_i(hit), .cmd_i(cmd), .stat_o(stat[b]));
      end
   endgenerate

   assign st_lock_o = stat[st_idx];
   assign op_prot   = stat[op_idx][0];

   fbp_op_gate u_gate (
      .clk(clk), .rst_n(rst_n), .start_i(op_start_i), .vpp_ok_i(vpp_ok_i),
      .blk_prot_i(op_prot), .clr_i(err_clr_i),
      .grant_o(op_grant_o), .deny_o(op_deny_o), .err_o(prot_err_o));

   // R2: every decoded address lands on an existing block
   a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_idx < IDX_W'(N_BLK)) && (op_idx < IDX_W'(N_BLK)) && (st_idx < IDX_W'(N_BLK)));
endmodule

// File: tb/fbp_prot_mgr_tb.sv
module fbp_prot_mgr_tb_top;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wp = 1'b1;
   logic [1:0] lk_cmd = 2'b00;
   logic [ADDR_W-1:0] lk_addr = '0;
   logic op_start = 1'b0;
   logic [ADDR_W-1:0] op_addr = '0;
   logic vpp_ok = 1'b1;
   logic err_clr = 1'b0;
   logic [ADDR_W-1:0] st_addr = '0;
   logic [ADDR_W-1:0] st_addr_b = '0;
   logic grant, deny, perr;
   logic [1:0] st_lock;
   logic grant_b, deny_b, perr_b;
   logic [1:0] st_lock_b;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   fbp_prot_mgr #(.TOP_BOOT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wp_i(wp), .lk_cmd_i(lk_cmd), .lk_addr_i(lk_addr),
      .op_start_i(op_start), .op_addr_i(op_addr), .vpp_ok_i(vpp_ok), .err_clr_i(err_clr),
      .op_grant_o(grant), .op_deny_o(deny), .prot_err_o(perr),
      .st_addr_i(st_addr), .st_lock_o(st_lock));

   fbp_prot_mgr #(.TOP_BOOT(1'b0)) dut_bot_i (
      .clk(clk), .rst_n(rst_n), .wp_i(wp), .lk_cmd_i(lk_cmd), .lk_addr_i(lk_addr),
      .op_start_i(op_start), .op_addr_i(op_addr), .vpp_ok_i(vpp_ok), .err_clr_i(err_clr),
      .op_grant_o(grant_b), .op_deny_o(deny_b), .prot_err_o(perr_b),
      .st_addr_i(st_addr_b), .st_lock_o(st_lock_b));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic req(input logic [1:0] c, input logic [ADDR_W-1:0] a);
      @(negedge clk);
      lk_cmd = c; lk_addr = a;
      @(negedge clk);
      lk_cmd = 2'b00;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] exp, input string r);
      st_addr = a; #1;
      check(st_lock == exp, r, st_lock, exp);
   endtask

   task automatic rd_b(input logic [ADDR_W-1:0] a, input logic [1:0] exp, input string r);
      st_addr_b = a; #1;
      check(st_lock_b == exp, r, st_lock_b, exp);
   endtask

   // start an operation; verdict sampled one falling edge later
   task automatic op(input logic [ADDR_W-1:0] a, input logic v, input logic v_after,
                     input logic exp_grant, input string r);
      @(negedge clk);
      op_start = 1'b1; op_addr = a; vpp_ok = v;
      @(negedge clk);
      op_start = 1'b0; vpp_ok = v_after;
      check(grant == exp_grant && deny == !exp_grant, r, {grant, deny}, {exp_grant, !exp_grant});
      @(negedge clk);
      check(!grant && !deny, {r, " pulse"}, {grant, deny}, 0);
      vpp_ok = 1'b1;
   endtask

   task automatic clear_err();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      rd(20'h00000, 2'b01, "R1 low block");
      rd(20'hFFFFF, 2'b01, "R1 top param block");
      rd(20'h80000, 2'b01, "R1 mid block");
      check(perr == 1'b0, "R1 err clear", perr, 0);
   endtask

   task automatic t_decode();
      wp = 1'b1;
      req(2'b10, 20'h00000);
      rd_b(20'h00FFF, 2'b00, "R2 bottom param 0 end");
      rd_b(20'h01000, 2'b01, "R2 bottom param 1 untouched");
      rd(20'h07FFF, 2'b00, "R2 top main 0 end");
      rd(20'h08000, 2'b01, "R2 top main 1 untouched");
      req(2'b10, 20'hFF000);
      rd(20'hFFFFF, 2'b00, "R2 top last param");
      rd(20'hFEFFF, 2'b01, "R2 top neighbour param");
      rd(20'hF7FFF, 2'b01, "R2 top last main");
      rd_b(20'hF8000, 2'b00, "R2 bottom last main start");
      rd_b(20'h08000, 2'b01, "R2 bottom first main");
   endtask

   task automatic t_lock_unlock();
      wp = 1'b1;
      req(2'b10, 20'h40000);
      rd(20'h47FFF, 2'b00, "R3 unlock");
      req(2'b01, 20'h40123);
      rd(20'h40000, 2'b01, "R3 lock");
      req(2'b10, 20'h40000);
   endtask

   task automatic t_op_ok();
      op(20'h40010, 1'b1, 1'b1, 1'b1, "R6 grant");
      check(perr == 1'b0, "R6 no error", perr, 0);
   endtask

   task automatic t_op_deny();
      op(20'h50000, 1'b1, 1'b1, 1'b0, "R7 locked deny");
      check(perr == 1'b1, "R7 error set", perr, 1);
      op(20'h40010, 1'b1, 1'b1, 1'b1, "R9 grant after error");
      check(perr == 1'b1, "R9 error sticky", perr, 1);
      clear_err();
      check(perr == 1'b0, "R9 error cleared", perr, 0);
   endtask

   task automatic t_vpp();
      op(20'h40010, 1'b0, 1'b0, 1'b0, "R7 lockout deny");
      check(perr == 1'b1, "R7 lockout error", perr, 1);
      clear_err();
      op(20'h40010, 1'b1, 1'b0, 1'b1, "R8 drop after start");
      check(perr == 1'b0, "R8 no error", perr, 0);
      op(20'h40010, 1'b0, 1'b1, 1'b0, "R8 rise after start");
      clear_err();
   endtask

   task automatic t_err_clr_race();
      @(negedge clk);
      err_clr = 1'b1; op_start = 1'b1; op_addr = 20'h50000;
      @(negedge clk);
      err_clr = 1'b0; op_start = 1'b0;
      check(perr == 1'b1, "R9 deny wins over clear", perr, 1);
      clear_err();
   endtask

   task automatic t_lockdown();
      wp = 1'b0;
      req(2'b11, 20'h60000);
      rd(20'h60000, 2'b11, "R4 lock-down");
      req(2'b10, 20'h60000);
      rd(20'h60000, 2'b11, "R4 unlock ignored");
      op(20'h60000, 1'b1, 1'b1, 1'b0, "R4 op denied");
      clear_err();
   endtask

   task automatic t_wp_high();
      wp = 1'b1;
      req(2'b10, 20'h60000);
      rd(20'h60000, 2'b10, "R5 unlock with wp high");
      op(20'h60000, 1'b1, 1'b1, 1'b1, "R5 op granted");
      @(negedge clk); wp = 1'b0;
      rd(20'h60000, 2'b11, "R5 wp low again");
      op(20'h60000, 1'b1, 1'b1, 1'b0, "R5 op denied again");
      clear_err();
      req(2'b01, 20'h60000);
      @(negedge clk); wp = 1'b1;
      rd(20'h60000, 2'b10, "R4 lock ignored while frozen");
      req(2'b01, 20'h60000);
      rd(20'h60000, 2'b11, "R10 lock keeps down bit");
   endtask

   task automatic t_reset_clears();
      op(20'h50000, 1'b1, 1'b1, 1'b0, "R7 deny before reset");
      do_reset();
      rd(20'h60000, 2'b01, "R10 reset clears lock-down");
      rd(20'h40000, 2'b01, "R1 reset relocks");
      check(perr == 1'b0, "R9 reset clears error", perr, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_decode();
      t_lock_unlock();
      t_op_ok();
      t_op_deny();
      t_vpp();
      t_err_clr_race();
      t_lockdown();
      t_wp_high();
      t_reset_clears();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule